// File: doc/BRIEF.md
# Addressed UART Receiver

This block turns an asynchronous serial line into characters. An external prescaler supplies a baud tick. The receiver counts ticks to find each bit centre, and the bit period is 16 ticks or 8 ticks depending on a speed-doubling control. Each bit is decided by a three-sample majority vote around its centre. A frame carries 8 or 9 data bits, least significant bit first, then an optional parity bit, then a stop bit.

Each finished character goes into a single-entry holding register. The register also keeps a ninth-bit output and three error flags that belong to that character: framing, overrun and parity. Reading the register empties it and clears the flags. Turning the receiver off flushes the register.

In multi-processor mode, every frame whose ninth bit is 0 is treated as a data frame and dropped. Only frames whose ninth bit is 1, which mark an address, reach the holding register. A receive-complete interrupt request is formed from the buffer-full state, a local enable and a global enable.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, `rx_valid`, `err_frame`, `err_overrun`, `err_parity` and `irq_rxc` are all 0.
- R2: With `dbl_speed` = 0 a bit lasts 16 baud ticks. With `dbl_speed` = 1 it lasts 8 baud ticks. Characters are received correctly whether a tick comes every clock or every second clock.
- R3: A falling edge on `rx_line` starts a frame only if the line is still low when the start bit's centre samples are voted. A low pulse shorter than half a bit produces no character.
- R4: Each bit is the majority of three samples taken on consecutive ticks at the bit centre, so a one-tick disturbance there does not change the bit. Data bits arrive least significant bit first.
- R5: When `nine_bits` = 1 the frame has 9 data bits and the last one appears on `rd_bit9`. When `nine_bits` = 0 the frame has 8 data bits and `rd_bit9` is 0.
- R6: A parity bit is expected and checked only when `par_mode[1]` = 1. `par_mode[0]` = 0 selects even parity over the data bits and 1 selects odd parity. On a mismatch `err_parity` is set with the character. When checking is off, `err_parity` stays 0.
- R7: If the stop bit samples low, `err_frame` is set and the character is still stored.
- R8: If a character completes while `rx_valid` = 1 and no read is given in that cycle, `err_overrun` is set and `rd_data` keeps the old character.
- R9: A one-cycle `rd_strobe` clears `rx_valid` and all three error flags. If a read falls in the same cycle as a new character completing, the read returns the old character and the new one is loaded with `err_overrun` = 0.
- R10: When `mp_mode` = 1, a frame whose ninth bit is 0 is discarded: it does not change `rx_valid` or raise `irq_rxc`. A frame whose ninth bit is 1 is stored.
- R11: When `rx_en` = 0, the buffer is emptied and all error flags are cleared, and no frame is received.
- R12: `irq_rxc` is 1 exactly when `rxc_ie`, `glob_ie` and `rx_valid` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial input line; it idles high |
| baud_tick | input | 1 | One-cycle oversampling tick from the prescaler |
| rx_en | input | 1 | Receiver enable; 0 flushes the buffer |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| par_mode | input | 2 | Bit 1 enables parity checking; bit 0 selects odd (1) or even (0) parity |
| mp_mode | input | 1 | Multi-processor mode: drop frames whose ninth bit is 0 |
| nine_bits | input | 1 | 1 selects 9 data bits per frame |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| rd_data | output | 8 | Lower 8 data bits of the held character |
| rd_bit9 | output | 1 | Ninth data bit of the held character |
| rx_valid | output | 1 | Holding register contains an unread character |
| err_frame | output | 1 | Stop bit of the held character was low |
| err_overrun | output | 1 | A character was lost while this one was unread |
| err_parity | output | 1 | Parity of the held character was wrong |
| irq_rxc | output | 1 | Receive-complete interrupt request |

## Verification
A read strobe and the completion of a new character can land in the same clock cycle. In that cycle the buffer must both give up the old character and take the new one, and it must not flag an overrun. To provoke this, the bench first measures, in clock cycles, the delay from a start edge to `rx_valid` for one frame. It then sends another frame while an unread character is in the buffer, and pulses `rd_strobe` exactly in the cycle of that measured delay. The result is judged correct if `rd_data` still showed the old character during the read, and if afterwards the new character is held with `err_overrun` = 0.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

   localparam int CHAR_W = 8;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_START,
      FS_DATA,
      FS_PAR,
      FS_STOP
   } frm_st_t;

   typedef struct packed {
      logic [CHAR_W-1:0] data;
      logic              nine;
      logic              ferr;
      logic              perr;
   } rx_char_t;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   if (STAGES < 1) begin : g_bad_stages
      $error("uarx_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= d_in;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], d_in};
      end
   end

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/uarx_sampler.sv
module uarx_sampler
   import uarx_pkg::*;
#(
   parameter int OSR_SLOW = 16,
   parameter int OSR_FAST = 8,
   parameter bit VOTE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic line,
   input  logic fast,
   input  logic restart,
   input  logic run,
   output logic bit_stb,
   output logic bit_val
);

   localparam int CW = $clog2(OSR_SLOW);
   localparam logic [CW-1:0] MID_SLOW  = CW'(OSR_SLOW / 2);
   localparam logic [CW-1:0] MID_FAST  = CW'(OSR_FAST / 2);
   localparam logic [CW-1:0] LAST_SLOW = CW'(OSR_SLOW - 1);
   localparam logic [CW-1:0] LAST_FAST = CW'(OSR_FAST - 1);

   if (OSR_FAST < 4 || (OSR_FAST % 2) != 0) begin : g_bad_fast
      $error("uarx_sampler: OSR_FAST must be even and at least 4");
   end
   if (OSR_SLOW <= OSR_FAST || (OSR_SLOW % 2) != 0) begin : g_bad_slow
      $error("uarx_sampler: OSR_SLOW must be even and above OSR_FAST");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] mid;
   logic [CW-1:0] last;
   logic          adv;

   always_comb begin
      mid  = fast ? MID_FAST  : MID_SLOW;
      last = fast ? LAST_FAST : LAST_SLOW;
      adv  = run && tick;
   end

   // tick position inside the current bit; the detecting tick is position 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= CW'(1);
      end else if (adv) begin
         cnt <= (cnt == last) ? '0 : cnt + CW'(1);
      end
   end

   assign bit_stb = adv && (cnt == mid + CW'(1));

   if (VOTE) begin : g_vote
      logic smp_lo;
      logic smp_mid;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            smp_lo  <= 1'b1;
            smp_mid <= 1'b1;
         end else if (adv) begin
            if (cnt == mid - CW'(1)) smp_lo  <= line;
            if (cnt == mid)          smp_mid <= line;
         end
      end
      assign bit_val = maj3(smp_lo, smp_mid, line);
   end else begin : g_single
      logic smp_mid;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    smp_mid <= 1'b1;
         else if (adv && cnt == mid)    smp_mid <= line;
      end
      assign bit_val = smp_mid;
   end

endmodule

// File: rtl/uarx_frame.sv
module uarx_frame
   import uarx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     en,
   input  logic     tick,
   input  logic     line,
   input  logic     bit_stb,
   input  logic     bit_val,
   input  logic     nine,
   input  logic     par_chk,
   input  logic     par_odd,
   output logic     restart,
   output logic     run,
   output logic     done,
   output rx_char_t chr
);

   frm_st_t         st;
   logic [CHAR_W:0] shf;
   logic [3:0]      bcnt;
   logic [3:0]      blast;
   logic            par_acc;
   logic            perr_q;

   assign blast   = nine ? 4'd8 : 4'd7;
   assign restart = en && (st == FS_IDLE) && tick && !line;
   assign run     = (st != FS_IDLE);
   assign done    = (st == FS_STOP) && bit_stb;

   always_comb begin
      chr.data = nine ? shf[CHAR_W-1:0] : shf[CHAR_W:1];
      chr.nine = nine & shf[CHAR_W];
      chr.ferr = ~bit_val;
      chr.perr = perr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FS_IDLE;
         shf     <= '0;
         bcnt    <= '0;
         par_acc <= 1'b0;
         perr_q  <= 1'b0;
      end else if (!en) begin
         st <= FS_IDLE;
      end else begin
         unique case (st)
            FS_IDLE: begin
               if (restart) begin
                  st      <= FS_START;
                  bcnt    <= '0;
                  par_acc <= 1'b0;
                  perr_q  <= 1'b0;
               end
            end
            FS_START: begin
               if (bit_stb) st <= bit_val ? FS_IDLE : FS_DATA;
            end
            FS_DATA: begin
               if (bit_stb) begin
                  shf     <= {bit_val, shf[CHAR_W:1]};
                  par_acc <= par_acc ^ bit_val;
                  bcnt    <= bcnt + 4'd1;
                  if (bcnt == blast) st <= par_chk ? FS_PAR : FS_STOP;
               end
            end
            FS_PAR: begin
               if (bit_stb) begin
                  perr_q <= ((par_acc ^ bit_val) != par_odd);
                  st     <= FS_STOP;
               end
            end
            FS_STOP: begin
               if (bit_stb) st <= FS_IDLE;
            end
            default: st <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uarx_buffer.sv
module uarx_buffer
   import uarx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              keep,
   input  rx_char_t          chr,
   input  logic              rd,
   output logic [CHAR_W-1:0] data,
   output logic              nine,
   output logic              valid,
   output logic              ferr,
   output logic              perr,
   output logic              ovr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         nine  <= 1'b0;
         valid <= 1'b0;
         ferr  <= 1'b0;
         perr  <= 1'b0;
         ovr   <= 1'b0;
      end else if (!en) begin
         data  <= '0;
         nine  <= 1'b0;
         valid <= 1'b0;
         ferr  <= 1'b0;
         perr  <= 1'b0;
         ovr   <= 1'b0;
      end else if (keep && (!valid || rd)) begin
         data  <= chr.data;
         nine  <= chr.nine;
         valid <= 1'b1;
         ferr  <= chr.ferr;
         perr  <= chr.perr;
         ovr   <= 1'b0;
      end else if (keep) begin
         ovr <= 1'b1;
      end else if (rd) begin
         valid <= 1'b0;
         ferr  <= 1'b0;
         perr  <= 1'b0;
         ovr   <= 1'b0;
      end
   end

endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx
   import uarx_pkg::*;
#(
   parameter int OSR_SLOW      = 16,
   parameter int OSR_FAST      = 8,
   parameter int SYNC_STAGES   = 2,
   parameter bit MAJORITY_VOTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              baud_tick,
   input  logic              rx_en,
   input  logic              dbl_speed,
   input  logic [1:0]        par_mode,
   input  logic              mp_mode,
   input  logic              nine_bits,
   input  logic              rxc_ie,
   input  logic              glob_ie,
   input  logic              rd_strobe,
   output logic [CHAR_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rx_valid,
   output logic              err_frame,
   output logic              err_overrun,
   output logic              err_parity,
   output logic              irq_rxc
);

   if (OSR_SLOW != 2 * OSR_FAST) begin : g_bad_ratio
      $error("mpc_uart_rx: OSR_SLOW must be twice OSR_FAST");
   end

   logic     line_s;
   logic     smp_restart;
   logic     frm_run;
   logic     bit_stb;
   logic     bit_val;
   logic     frm_done;
   logic     frm_keep;
   rx_char_t frm_chr;

   uarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_line),
      .d_out (line_s)
   );

   uarx_sampler #(
      .OSR_SLOW (OSR_SLOW),
      .OSR_FAST (OSR_FAST),
      .VOTE     (MAJORITY_VOTE)
   ) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (baud_tick),
      .line    (line_s),
      .fast    (dbl_speed),
      .restart (smp_restart),
      .run     (frm_run),
      .bit_stb (bit_stb),
      .bit_val (bit_val)
   );

   uarx_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (rx_en),
      .tick    (baud_tick),
      .line    (line_s),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .nine    (nine_bits),
      .par_chk (par_mode[1]),
      .par_odd (par_mode[0]),
      .restart (smp_restart),
      .run     (frm_run),
      .done    (frm_done),
      .chr     (frm_chr)
   );

   // address filter: in multi-processor mode only ninth-bit-set frames pass
   assign frm_keep = frm_done && !(mp_mode && !frm_chr.nine);

   uarx_buffer u_buffer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rx_en),
      .keep  (frm_keep),
      .chr   (frm_chr),
      .rd    (rd_strobe),
      .data  (rd_data),
      .nine  (rd_bit9),
      .valid (rx_valid),
      .ferr  (err_frame),
      .perr  (err_parity),
      .ovr   (err_overrun)
   );

   assign irq_rxc = rxc_ie & glob_ie & rx_valid;

endmodule

// File: rtl/uarx_chk.sv
module uarx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_en,
   input logic       rd_strobe,
   input logic       mp_mode,
   input logic       par_chk,
   input logic       frm_done,
   input logic       frm_keep,
   input logic [7:0] rd_data,
   input logic       rx_valid,
   input logic       err_frame,
   input logic       err_overrun,
   input logic       err_parity,
   input logic       irq_rxc
);

   AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rxc |-> rx_valid); // R12

   AST_FLAGS_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frame || err_overrun || err_parity) |-> rx_valid); // R7

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rd_strobe && !frm_keep) |=>
      (!rx_valid && !err_frame && !err_overrun && !err_parity)); // R9

   AST_READ_AND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && frm_keep && (!rx_valid || rd_strobe)) |=>
      (rx_valid && !err_overrun)); // R9

   AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && rx_valid && frm_keep && !rd_strobe) |=>
      (err_overrun && rx_valid && $stable(rd_data))); // R8

   AST_MP_DROPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && mp_mode && frm_done && !frm_keep && !rx_valid) |=> !rx_valid); // R10

   AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!rx_valid && !err_frame && !err_overrun && !err_parity)); // R11

   AST_NO_PARITY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && !par_chk && frm_keep && (!rx_valid || rd_strobe)) |=> !err_parity); // R6

endmodule

bind mpc_uart_rx uarx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_en       (rx_en),
   .rd_strobe   (rd_strobe),
   .mp_mode     (mp_mode),
   .par_chk     (par_mode[1]),
   .frm_done    (frm_done),
   .frm_keep    (frm_keep),
   .rd_data     (rd_data),
   .rx_valid    (rx_valid),
   .err_frame   (err_frame),
   .err_overrun (err_overrun),
   .err_parity  (err_parity),
   .irq_rxc     (irq_rxc)
);

// File: tb/mpc_uart_rx_bench.sv
`timescale 1ns/1ps
module mpc_uart_rx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       baud_tick = 1'b0;
   logic       rx_en = 1'b0;
   logic       dbl_speed = 1'b0;
   logic [1:0] par_mode = 2'b00;
   logic       mp_mode = 1'b0;
   logic       nine_bits = 1'b0;
   logic       rxc_ie = 1'b0;
   logic       glob_ie = 1'b0;
   logic       rd_auto = 1'b0;
   logic       rd_man = 1'b0;
   logic       rd_strobe;
   logic [7:0] rd_data;
   logic       rd_bit9, rx_valid, err_frame, err_overrun, err_parity, irq_rxc;

   assign rd_strobe = rd_auto | rd_man;

   always #10 clk = ~clk; // 50 MHz

   mpc_uart_rx u_mpc_uart_rx (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
      .rx_en(rx_en), .dbl_speed(dbl_speed), .par_mode(par_mode),
      .mp_mode(mp_mode), .nine_bits(nine_bits), .rxc_ie(rxc_ie),
      .glob_ie(glob_ie), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .rd_bit9(rd_bit9), .rx_valid(rx_valid), .err_frame(err_frame),
      .err_overrun(err_overrun), .err_parity(err_parity), .irq_rxc(irq_rxc)
   );

   int  total = 0;
   int  bad = 0;
   int  tick_div = 1;
   int  tick_cnt = 0;
   bit  auto_rd = 1'b0;
   bit  finished = 1'b0;

   typedef struct {
      logic [7:0] d;
      logic       b9;
      logic       fe;
      logic       pe;
      logic       ov;
      string      req;
   } exp_t;

   exp_t exp_q[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push_exp(input logic [7:0] d, input logic b9, input logic fe,
                           input logic pe, input string req);
      exp_t e;
      e.d = d; e.b9 = b9; e.fe = fe; e.pe = pe; e.ov = 1'b0; e.req = req;
      exp_q.push_back(e);
   endtask

   // baud tick generator
   always @(negedge clk) begin
      if (tick_cnt >= tick_div - 1) begin
         tick_cnt  <= 0;
         baud_tick <= 1'b1;
      end else begin
         tick_cnt  <= tick_cnt + 1;
         baud_tick <= 1'b0;
      end
   end

   // scoreboard monitor: reads every new character and compares it
   always @(negedge clk) begin
      rd_auto <= 1'b0;
      if (auto_rd && rx_valid && !rd_auto) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10", "unexpected character", rd_data, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rd_data == e.d, e.req, "data", rd_data, e.d);
            chk(rd_bit9 == e.b9, e.req, "ninth bit", rd_bit9, e.b9);
            chk(err_frame == e.fe, e.req, "frame error", err_frame, e.fe);
            chk(err_parity == e.pe, e.req, "parity error", err_parity, e.pe);
            chk(err_overrun == e.ov, e.req, "overrun", err_overrun, e.ov);
         end
         rd_auto <= 1'b1;
      end
   end

   function automatic int bit_len();
      return (dbl_speed ? 8 : 16) * tick_div;
   endfunction

   // drives one frame; gbit >= 0 puts a one-cycle glitch in that data bit centre
   task automatic send_frame(input logic [8:0] v, input int nb, input bit has_par,
                             input bit pbit, input bit stop_v, input int gbit);
      int bl;
      bl = bit_len();
      rx_line = 1'b0;
      repeat (bl) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rx_line = v[i];
         if (i == gbit) begin
            repeat (bl / 2 - 1) @(negedge clk);
            rx_line = ~v[i];
            @(negedge clk);
            rx_line = v[i];
            repeat (bl - bl / 2) @(negedge clk);
         end else begin
            repeat (bl) @(negedge clk);
         end
      end
      if (has_par) begin
         rx_line = pbit;
         repeat (bl) @(negedge clk);
      end
      rx_line = stop_v;
      repeat (bl) @(negedge clk);
      rx_line = 1'b1;
      repeat (2 * bl) @(negedge clk);
   endtask

   task automatic drained(input string req);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, req, "characters still expected", exp_q.size(), 0);
   endtask

   task automatic manual_read();
      rd_man = 1'b1;
      @(negedge clk);
      rd_man = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: run did not end actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int lat;
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(rx_valid == 1'b0, "R1", "valid after reset", rx_valid, 0);
      chk(err_frame == 1'b0, "R1", "frame flag after reset", err_frame, 0);
      chk(err_overrun == 1'b0, "R1", "overrun flag after reset", err_overrun, 0);
      chk(err_parity == 1'b0, "R1", "parity flag after reset", err_parity, 0);
      chk(irq_rxc == 1'b0, "R1", "irq after reset", irq_rxc, 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      auto_rd = 1'b1;
      repeat (5) @(negedge clk);

      // R2 / R4: normal speed, LSB first
      push_exp(8'hA5, 0, 0, 0, "R4");
      send_frame(9'h0A5, 8, 0, 0, 1, -1);
      push_exp(8'h3C, 0, 0, 0, "R2");
      send_frame(9'h03C, 8, 0, 0, 1, -1);
      // R2 double speed
      dbl_speed = 1'b1;
      push_exp(8'h5A, 0, 0, 0, "R2");
      send_frame(9'h05A, 8, 0, 0, 1, -1);
      // R2 tick every second clock
      dbl_speed = 1'b0;
      tick_div = 2;
      repeat (4) @(negedge clk);
      push_exp(8'h81, 0, 0, 0, "R2");
      send_frame(9'h081, 8, 0, 0, 1, -1);
      tick_div = 1;
      repeat (4) @(negedge clk);
      drained("R2");

      // R4 glitch at bit centre
      push_exp(8'hC6, 0, 0, 0, "R4");
      send_frame(9'h0C6, 8, 0, 0, 1, 2);
      push_exp(8'h39, 0, 0, 0, "R4");
      send_frame(9'h039, 8, 0, 0, 1, 5);
      drained("R4");

      // R3 short start pulse
      rx_line = 1'b0;
      repeat (3) @(negedge clk);
      rx_line = 1'b1;
      repeat (40) @(negedge clk);
      chk(rx_valid == 1'b0, "R3", "valid after short pulse", rx_valid, 0);
      push_exp(8'h77, 0, 0, 0, "R3");
      send_frame(9'h077, 8, 0, 0, 1, -1);
      drained("R3");

      // R5 nine data bits
      nine_bits = 1'b1;
      push_exp(8'h2B, 1, 0, 0, "R5");
      send_frame(9'h12B, 9, 0, 0, 1, -1);
      push_exp(8'hF0, 0, 0, 0, "R5");
      send_frame(9'h0F0, 9, 0, 0, 1, -1);
      nine_bits = 1'b0;
      drained("R5");

      // R6 parity
      par_mode = 2'b10;
      push_exp(8'h13, 0, 0, 0, "R6");
      send_frame(9'h013, 8, 1, ^8'h13, 1, -1);
      push_exp(8'h13, 0, 0, 1, "R6");
      send_frame(9'h013, 8, 1, ~^8'h13, 1, -1);
      par_mode = 2'b11;
      push_exp(8'h6E, 0, 0, 0, "R6");
      send_frame(9'h06E, 8, 1, ~^8'h6E, 1, -1);
      push_exp(8'h6E, 0, 0, 1, "R6");
      send_frame(9'h06E, 8, 1, ^8'h6E, 1, -1);
      par_mode = 2'b00;
      drained("R6");

      // R7 stop bit low
      push_exp(8'h4D, 0, 1, 0, "R7");
      send_frame(9'h04D, 8, 0, 0, 0, -1);
      drained("R7");

      // R10 multi-processor filtering
      mp_mode = 1'b1;
      nine_bits = 1'b1;
      send_frame(9'h055, 9, 0, 0, 1, -1);
      chk(rx_valid == 1'b0, "R10", "valid after data frame", rx_valid, 0);
      push_exp(8'h42, 1, 0, 0, "R10");
      send_frame(9'h142, 9, 0, 0, 1, -1);
      drained("R10");
      mp_mode = 1'b0;
      nine_bits = 1'b0;

      // R8 overrun, R12 interrupt
      auto_rd = 1'b0;
      repeat (4) @(negedge clk);
      send_frame(9'h011, 8, 0, 0, 1, -1);
      send_frame(9'h022, 8, 0, 0, 1, -1);
      chk(rx_valid == 1'b1, "R8", "valid after overrun", rx_valid, 1);
      chk(rd_data == 8'h11, "R8", "old data kept", rd_data, 8'h11);
      chk(err_overrun == 1'b1, "R8", "overrun flag", err_overrun, 1);
      rxc_ie = 1'b1; glob_ie = 1'b0;
      @(negedge clk);
      chk(irq_rxc == 1'b0, "R12", "irq with global off", irq_rxc, 0);
      glob_ie = 1'b1;
      @(negedge clk);
      chk(irq_rxc == 1'b1, "R12", "irq with all set", irq_rxc, 1);
      rxc_ie = 1'b0;
      @(negedge clk);
      chk(irq_rxc == 1'b0, "R12", "irq with local off", irq_rxc, 0);
      rxc_ie = 1'b1;
      manual_read();
      chk(rx_valid == 1'b0, "R9", "valid after read", rx_valid, 0);
      chk(err_overrun == 1'b0, "R9", "overrun after read", err_overrun, 0);
      chk(irq_rxc == 1'b0, "R12", "irq with empty buffer", irq_rxc, 0);

      // R9 read coinciding with completion
      lat = 0;
      fork
         send_frame(9'h0AA, 8, 0, 0, 1, -1);
         begin
            while (!rx_valid) begin
               @(negedge clk);
               lat++;
            end
         end
      join
      manual_read();
      send_frame(9'h0BB, 8, 0, 0, 1, -1);
      fork
         send_frame(9'h0CC, 8, 0, 0, 1, -1);
         begin
            repeat (lat - 1) @(negedge clk);
            chk(rd_data == 8'hBB, "R9", "data during coincident read", rd_data, 8'hBB);
            rd_man = 1'b1;
            @(negedge clk);
            rd_man = 1'b0;
            chk(rx_valid == 1'b1, "R9", "valid after coincident read", rx_valid, 1);
            chk(rd_data == 8'hCC, "R9", "new data loaded", rd_data, 8'hCC);
            chk(err_overrun == 1'b0, "R9", "no overrun on coincident read", err_overrun, 0);
         end
      join
      manual_read();

      // R11 disable flush
      send_frame(9'h066, 8, 0, 0, 0, -1);
      chk(err_frame == 1'b1, "R11", "frame flag before disable", err_frame, 1);
      rx_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(rx_valid == 1'b0, "R11", "valid after disable", rx_valid, 0);
      chk(err_frame == 1'b0, "R11", "frame flag after disable", err_frame, 0);
      send_frame(9'h099, 8, 0, 0, 1, -1);
      chk(rx_valid == 1'b0, "R11", "no reception while disabled", rx_valid, 0);
      rx_en = 1'b1;
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule